// File: doc/BRIEF.md
# Software-probed set-associative translation buffer

This block is the tag and data array of a page translation buffer with 32 entries, arranged as four ways of eight rows, that software reaches directly through two 32-bit registers. A command register carries a linear page number, a valid bit, three attribute controls and an operation bit. A result register carries a physical page number, a hit flag and a way number. Loading the command register performs the operation at once. A write places the tag into the way named by the result register. A lookup compares every way at the selected row and reports the outcome in the result register one clock later.

The dirty, user and writable attributes are each driven by a true/complement pair. On a write, the pair sets the stored value. On a lookup, it says whether an entry with that attribute at 0 or at 1 qualifies. The valid bit is compared exactly like a page-address bit, so a lookup that asks for valid entries never matches an entry that has never been written. The row is chosen by the low three bits of the linear page number.

Top module: `tlb_probe_array`

## Requirements
- R1: After reset, both registers read 0 and every entry is invalid with page 0, so a lookup with the valid bit at 1 misses.
- R2: The command register reads back the last value loaded, with bits 4:1 forced to 0. The layout is: page [31:12], valid [11], dirty true/complement [10]/[9], user true/complement [8]/[7], writable true/complement [6]/[5], operation [0] (0 = write, 1 = lookup).
- R3: A load of the result register alone keeps bits 31:12 (physical page), 4 (hit flag) and 3:2 (way) and reads 0 in all other bits.
- R4: A write stores page, valid bit, attributes and the result register's physical page into the way given by result bits 3:2, at the row given by page bits 2:0 (linear address bits 14:12). A true/complement pair of 1/0 stores 1 and a pair of 0/1 stores 0.
- R5: A lookup whose page and valid bit equal an entry in the selected row, and whose attribute qualifiers all accept it, leaves the result register at physical page, hit flag 1 and the matching way in the cycle after the load.
- R6: A lookup with no matching entry leaves the result register at all zeros.
- R7: On a lookup, pair 1/0 accepts only entries with that attribute at 1 and pair 0/1 accepts only entries with it at 0; a rejected attribute gives a miss.
- R8: An entry written with the valid bit at 0 is found only by a lookup that also has the valid bit at 0.
- R9: Entries in different ways of the same row are independent, and a lookup reports the way that actually holds the page.
- R10: A write to an occupied way and row replaces the old entry, and the old page then misses.
- R11: A write operation leaves the result register unchanged.
- R12: When a lookup and a result-register load occur in the same cycle, the lookup result is kept. When a write and a result-register load coincide, the entry takes the result register's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Load strobe for the command register; starts the operation |
| cmd_wdata | input | 32 | Command register value |
| data_we | input | 1 | Load strobe for the result register |
| data_wdata | input | 32 | Result register value |
| cmd_rdata | output | 32 | Command register contents |
| data_rdata | output | 32 | Result register contents |

## Verification
On every cycle, the checker confirms four things: the register readback masks for both registers; that a write leaves the result register untouched; that a lookup's hit flag agrees with the per-way compare outputs and a miss clears the whole register; and that at most one way matches a valid lookup. Whether the stored tag, attribute values and physical page land in the right way and row can only be shown by the bench. It writes entries, reads them back through lookups, and compares the results with a model of the array. Its scenarios cover the attribute qualifiers, valid-bit compares, same-row conflicts across ways, replacement and coincident strobes.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  localparam int LIN_PAGE_W = 20;
  localparam int ATTR_N     = 3;   // index 2 = dirty, 1 = user, 0 = writable

  // Command register bit positions (decoded by software, so fixed)
  localparam int CMD_VALID_BIT = 11;
  localparam int CMD_OP_BIT    = 0;
  localparam logic [31:0] CMD_KEEP  = 32'hFFFF_FFE1;
  localparam logic [31:0] DATA_KEEP = 32'hFFFF_F01C;
  localparam int DATA_HIT_BIT = 4;
  localparam int DATA_WAY_LSB = 2;

  typedef struct packed {
    logic [LIN_PAGE_W-1:0] page;
    logic                  valid;
    logic [ATTR_N-1:0]     attr;
  } tlbp_tag_t;

  typedef struct packed {
    logic [LIN_PAGE_W-1:0] page;
    logic                  valid;
    logic [ATTR_N-1:0]     pos;
    logic [ATTR_N-1:0]     neg;
    logic                  is_lookup;
  } tlbp_cmd_t;

  // An attribute qualifies when the pair half for its stored value is set
  function automatic logic attr_accepts(input logic stored, input logic p, input logic n);
    return (stored & p) | (~stored & n);
  endfunction

endpackage

// File: rtl/tlbp_cmd_decode.sv
module tlbp_cmd_decode
  import tlbp_pkg::*;
(
  input  logic [31:0] raw,
  output tlbp_cmd_t   cmd
);

  always_comb begin
    cmd.page      = raw[31:32-LIN_PAGE_W];
    cmd.valid     = raw[CMD_VALID_BIT];
    cmd.pos       = {raw[10], raw[8], raw[6]};
    cmd.neg       = {raw[9],  raw[7], raw[5]};
    cmd.is_lookup = raw[CMD_OP_BIT];
  end

endmodule

// File: rtl/tlbp_way.sv
module tlbp_way
  import tlbp_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ROW_W-1:0]      wr_row,
  input  tlbp_tag_t             wr_tag,
  input  logic [LIN_PAGE_W-1:0] wr_phys,
  input  logic [ROW_W-1:0]      lk_row,
  input  logic [LIN_PAGE_W-1:0] lk_page,
  input  logic                  lk_valid,
  input  logic [ATTR_N-1:0]     lk_pos,
  input  logic [ATTR_N-1:0]     lk_neg,
  output logic                  hit,
  output logic [LIN_PAGE_W-1:0] hit_phys
);

  tlbp_tag_t             tag_q  [ROWS];
  logic [LIN_PAGE_W-1:0] phys_q [ROWS];
  logic [ROWS-1:0]       row_we;

  // Row write enables
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_we[r] = wr_en && (wr_row == ROW_W'(r));
    end
  end

  // Entry storage with explicit clock enables
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[r]  <= '0;
        phys_q[r] <= '0;
      end else if (row_we[r]) begin
        tag_q[r]  <= wr_tag;
        phys_q[r] <= wr_phys;
      end
    end
  end

  // Compare at the selected row
  tlbp_tag_t       sel_tag;
  logic [ATTR_N-1:0] attr_ok;

  always_comb begin
    sel_tag = tag_q[lk_row];
    for (int a = 0; a < ATTR_N; a++) begin
      attr_ok[a] = attr_accepts(sel_tag.attr[a], lk_pos[a], lk_neg[a]);
    end
    hit      = (sel_tag.page == lk_page) && (sel_tag.valid == lk_valid) && (&attr_ok);
    hit_phys = phys_q[lk_row];
  end

endmodule

// File: rtl/tlbp_hit_select.sv
module tlbp_hit_select
  import tlbp_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       way_hit,
  input  logic [LIN_PAGE_W-1:0] way_phys [WAYS],
  output logic                  any_hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [LIN_PAGE_W-1:0] hit_phys
);

  // Lowest-numbered way wins if duplicates were ever written
  always_comb begin
    any_hit  = |way_hit;
    hit_way  = '0;
    hit_phys = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit_way  = WAY_W'(w);
        hit_phys = way_phys[w];
      end
    end
  end

endmodule

// File: rtl/tlb_probe_array.sv
module tlb_probe_array
  import tlbp_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int ROWS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        data_we,
  input  logic [31:0] data_wdata,
  output logic [31:0] cmd_rdata,
  output logic [31:0] data_rdata
);

  localparam int WAY_W = $clog2(WAYS);
  localparam int ROW_W = $clog2(ROWS);

  logic [31:0] cmd_q, cmd_n;
  logic [31:0] data_q, data_n;
  tlbp_cmd_t   cmd;
  tlbp_tag_t   wr_tag;
  logic [WAY_W-1:0]      rep_q;
  logic [ROW_W-1:0]      row_sel;
  logic                  do_write, do_lookup;
  logic [WAYS-1:0]       way_hit;
  logic [LIN_PAGE_W-1:0] way_phys [WAYS];
  logic                  any_hit;
  logic [WAY_W-1:0]      hit_way;
  logic [LIN_PAGE_W-1:0] hit_phys;
  logic [31:0]           lookup_res;

  tlbp_cmd_decode u_dec (
    .raw (cmd_wdata),
    .cmd (cmd)
  );

  always_comb begin
    rep_q     = data_q[DATA_WAY_LSB +: WAY_W];
    row_sel   = cmd.page[ROW_W-1:0];
    do_write  = cmd_we && !cmd.is_lookup;
    do_lookup = cmd_we &&  cmd.is_lookup;
    wr_tag.page  = cmd.page;
    wr_tag.valid = cmd.valid;
    wr_tag.attr  = cmd.pos;
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlbp_way #(.ROWS(ROWS), .ROW_W(ROW_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (do_write && (rep_q == WAY_W'(g))),
      .wr_row   (row_sel),
      .wr_tag   (wr_tag),
      .wr_phys  (data_q[31:32-LIN_PAGE_W]),
      .lk_row   (row_sel),
      .lk_page  (cmd.page),
      .lk_valid (cmd.valid),
      .lk_pos   (cmd.pos),
      .lk_neg   (cmd.neg),
      .hit      (way_hit[g]),
      .hit_phys (way_phys[g])
    );
  end

  tlbp_hit_select #(.WAYS(WAYS), .WAY_W(WAY_W)) u_sel (
    .way_hit  (way_hit),
    .way_phys (way_phys),
    .any_hit  (any_hit),
    .hit_way  (hit_way),
    .hit_phys (hit_phys)
  );

  // Result word; a miss clears everything
  always_comb begin
    lookup_res = '0;
    if (any_hit) begin
      lookup_res[31:32-LIN_PAGE_W]          = hit_phys;
      lookup_res[DATA_HIT_BIT]              = 1'b1;
      lookup_res[DATA_WAY_LSB +: WAY_W]     = hit_way;
    end
  end

  // Next-state logic
  always_comb begin
    cmd_n = cmd_q;
    if (cmd_we) cmd_n = cmd_wdata & CMD_KEEP;
    data_n = data_q;
    if (do_lookup)    data_n = lookup_res;
    else if (data_we) data_n = data_wdata & DATA_KEEP;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_n;
      data_q <= data_n;
    end
  end

  assign cmd_rdata  = cmd_q;
  assign data_rdata = data_q;

endmodule

// File: rtl/tlbp_checker.sv
module tlbp_checker #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_we,
  input logic [31:0]     cmd_wdata,
  input logic            data_we,
  input logic [31:0]     data_wdata,
  input logic [31:0]     cmd_rdata,
  input logic [31:0]     data_rdata,
  input logic [WAYS-1:0] way_hit
);

  // R2: command readback with reserved bits cleared
  assert_cmd_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (cmd_rdata == ($past(cmd_wdata) & 32'hFFFF_FFE1)));

  // R3: result register load alone
  assert_data_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !cmd_we) |=> (data_rdata == ($past(data_wdata) & 32'hFFFF_F01C)));

  // R11: a write operation never disturbs the result register
  assert_write_keeps_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_wdata[0] && !data_we) |=> $stable(data_rdata));

  // R5: hit flag follows the per-way compares
  assert_hit_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0]) |=> (data_rdata[4] == $past(|way_hit)));

  // R6: a miss clears the whole result
  assert_miss_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0]) |=> (data_rdata[4] || (data_rdata == 32'h0)));

  // R9: with unique tags, a valid lookup matches in at most one way
  assert_single_way_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0] && cmd_wdata[11]) |-> $onehot0(way_hit));

endmodule

bind tlb_probe_array tlbp_checker #(.WAYS(WAYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_we     (cmd_we),
  .cmd_wdata  (cmd_wdata),
  .data_we    (data_we),
  .data_wdata (data_wdata),
  .cmd_rdata  (cmd_rdata),
  .data_rdata (data_rdata),
  .way_hit    (way_hit)
);

// File: tb/tlb_probe_array_tb_top.sv
module tlb_probe_array_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cmd_we;
  logic [31:0] cmd_wdata;
  logic        data_we;
  logic [31:0] data_wdata;
  logic [31:0] cmd_rdata;
  logic [31:0] data_rdata;

  int n_tests;
  int n_fail;
  bit done;

  tlb_probe_array dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .cmd_rdata  (cmd_rdata),
    .data_rdata (data_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Model of the array
  logic [19:0] m_page [4][8];
  logic        m_v    [4][8];
  logic [2:0]  m_attr [4][8];
  logic [19:0] m_phys [4][8];
  logic [31:0] m_data;

  function automatic logic [31:0] mk_cmd(input logic [19:0] page, input logic v,
                                         input logic [2:0] pos, input logic [2:0] neg,
                                         input logic op);
    return {page, v, pos[2], neg[2], pos[1], neg[1], pos[0], neg[0], 4'b0, op};
  endfunction

  function automatic logic [31:0] exp_lookup(input logic [19:0] page, input logic v,
                                             input logic [2:0] pos, input logic [2:0] neg);
    logic [31:0] r;
    logic ok;
    r = 32'h0;
    for (int w = 3; w >= 0; w--) begin
      ok = (m_page[w][page[2:0]] == page) && (m_v[w][page[2:0]] == v);
      for (int a = 0; a < 3; a++) begin
        if (m_attr[w][page[2:0]][a] ? !pos[a] : !neg[a]) ok = 1'b0;
      end
      if (ok) r = {m_phys[w][page[2:0]], 7'b0, 1'b1, 2'(w), 2'b0};
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit cw, input logic [31:0] cv, input bit dw, input logic [31:0] dv);
    @(negedge clk);
    cmd_we = cw; cmd_wdata = cv; data_we = dw; data_wdata = dv;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0;
  endtask

  task automatic load_data(input logic [31:0] v);
    pulse(1'b0, 32'h0, 1'b1, v);
    m_data = v & 32'hFFFF_F01C;
  endtask

  task automatic write_entry(input int way, input logic [19:0] page, input logic v,
                             input logic [2:0] attr, input logic [19:0] phys);
    load_data({phys, 7'b0, 1'b0, 2'(way), 2'b0});
    pulse(1'b1, mk_cmd(page, v, attr, ~attr, 1'b0), 1'b0, 32'h0);
    m_page[way][page[2:0]] = page;
    m_v[way][page[2:0]]    = v;
    m_attr[way][page[2:0]] = attr;
    m_phys[way][page[2:0]] = phys;
  endtask

  task automatic lookup(input logic [19:0] page, input logic v, input logic [2:0] pos,
                        input logic [2:0] neg, input string req);
    logic [31:0] e;
    e = exp_lookup(page, v, pos, neg);
    pulse(1'b1, mk_cmd(page, v, pos, neg, 1'b1), 1'b0, 32'h0);
    m_data = e;
    check(data_rdata == e, req, data_rdata, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    n_tests = 0; n_fail = 0; done = 1'b0;
    s = $urandom(32'h5EED_1234);
    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 8; r++) begin
        m_page[w][r] = '0; m_v[w][r] = 1'b0; m_attr[w][r] = '0; m_phys[w][r] = '0;
      end
    m_data = 32'h0;
    rst_n = 1'b0; cmd_we = 1'b0; cmd_wdata = '0; data_we = 1'b0; data_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(cmd_rdata == 32'h0, "R1", cmd_rdata, 32'h0);
    check(data_rdata == 32'h0, "R1", data_rdata, 32'h0);
    lookup(20'h0_0005, 1'b1, 3'b101, 3'b010, "R1");

    // R3: result register masking
    load_data(32'hFFFF_FFFF);
    check(data_rdata == 32'hFFFF_F01C, "R3", data_rdata, 32'hFFFF_F01C);

    // R2: command readback (a lookup that misses)
    pulse(1'b1, 32'hFFFF_FD5F, 1'b0, 32'h0);
    check(cmd_rdata == 32'hFFFF_FD41, "R2", cmd_rdata, 32'hFFFF_FD41);
    check(data_rdata == 32'h0, "R6", data_rdata, 32'h0);

    // R4/R5/R11: write then find
    write_entry(2, 20'h1_2343, 1'b1, 3'b101, 20'hABCDE);
    check(data_rdata == 32'hABCD_E008, "R11", data_rdata, 32'hABCD_E008);
    lookup(20'h1_2343, 1'b1, 3'b101, 3'b010, "R4");
    check(data_rdata == 32'hABCD_E018, "R5", data_rdata, 32'hABCD_E018);

    // R7: each qualifier rejects the wrong value
    lookup(20'h1_2343, 1'b1, 3'b001, 3'b110, "R7");
    lookup(20'h1_2343, 1'b1, 3'b111, 3'b000 | 3'b000, "R7");
    lookup(20'h1_2343, 1'b1, 3'b100, 3'b011, "R7");
    check(data_rdata == 32'h0, "R7", data_rdata, 32'h0);

    // R8: valid bit compared as an address bit
    write_entry(1, 20'h5_5553, 1'b0, 3'b010, 20'h13579);
    lookup(20'h5_5553, 1'b1, 3'b010, 3'b101, "R8");
    lookup(20'h5_5553, 1'b0, 3'b010, 3'b101, "R8");
    check(data_rdata == 32'h1357_9014, "R8", data_rdata, 32'h1357_9014);

    // R9: all ways of one row
    write_entry(0, 20'h0_A006, 1'b1, 3'b000, 20'h00111);
    write_entry(1, 20'h0_B006, 1'b1, 3'b111, 20'h00222);
    write_entry(2, 20'h0_C006, 1'b1, 3'b011, 20'h00333);
    write_entry(3, 20'h0_D006, 1'b1, 3'b100, 20'h00444);
    lookup(20'h0_A006, 1'b1, 3'b000, 3'b111, "R9");
    lookup(20'h0_B006, 1'b1, 3'b111, 3'b000, "R9");
    lookup(20'h0_C006, 1'b1, 3'b011, 3'b100, "R9");
    lookup(20'h0_D006, 1'b1, 3'b100, 3'b011, "R9");
    check(data_rdata == 32'h0044_401C, "R9", data_rdata, 32'h0044_401C);

    // R10: replacement
    write_entry(2, 20'h0_E006, 1'b1, 3'b011, 20'h00555);
    lookup(20'h0_C006, 1'b1, 3'b011, 3'b100, "R10");
    lookup(20'h0_E006, 1'b1, 3'b011, 3'b100, "R10");

    // R12: coincident strobes
    pulse(1'b1, mk_cmd(20'h0_B006, 1'b1, 3'b111, 3'b000, 1'b1), 1'b1, 32'h7777_7000);
    check(data_rdata == 32'h0022_2014, "R12", data_rdata, 32'h0022_2014);
    load_data({20'h0F0F0, 7'b0, 1'b0, 2'd3, 2'b0});
    pulse(1'b1, mk_cmd(20'h0_7771, 1'b1, 3'b110, 3'b001, 1'b0), 1'b1, {20'h11111, 12'h004});
    m_page[3][1] = 20'h0_7771; m_v[3][1] = 1'b1; m_attr[3][1] = 3'b110; m_phys[3][1] = 20'h0F0F0;
    m_data = {20'h11111, 12'h004};
    check(data_rdata == 32'h1111_1004, "R12", data_rdata, 32'h1111_1004);
    lookup(20'h0_7771, 1'b1, 3'b110, 3'b001, "R12");

    // Random mix; random pages have bit 19 set and encode their way and row
    for (int i = 0; i < 400; i++) begin
      int way;
      int row;
      logic [19:0] pg;
      logic [2:0] pos;
      way = int'($urandom_range(3));
      row = int'($urandom_range(7));
      if ($urandom_range(1) == 0) begin
        pg = {1'b1, 14'($urandom), 2'(way), 3'(row)};
        write_entry(way, pg, 1'($urandom_range(1)), 3'($urandom), 20'($urandom));
        check(data_rdata == m_data, "R11", data_rdata, m_data);
      end else begin
        if ($urandom_range(3) != 0) begin
          pos = m_attr[way][row];
          if ($urandom_range(3) == 0) pos[$urandom_range(2)] ^= 1'b1;
          lookup(m_page[way][row], ($urandom_range(7) == 0) ? ~m_v[way][row] : m_v[way][row],
                 pos, ~pos, "R5");
        end else begin
          pos = 3'($urandom);
          lookup({1'b1, 19'($urandom)}, 1'b1, pos, ~pos, "R6");
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule